// File: doc/BRIEF.md
# Instruction-Driven Serial Register Interface

This block is the host-facing serial port of a data-acquisition controller. A host selects it with an active-low chip select, toggles a serial clock and moves data on a data-in and a data-out line. The first byte of every frame is an instruction. When its top bit is set, the instruction is a conversion command. It loads its low seven bits into the gain/mux register and pulses a conversion-start strobe. When its top bit is clear, the instruction addresses one 8-bit register for a one-byte or two-byte read or write.

Several settings shape the serial traffic. A strap pin picks which serial clock edge is active. Register bits pick the bit order and a 2-wire mode, in which read data also appears on the data-in line. Another register bit releases the data line early. A read-back setting can make a conversion command flow straight into a 2-byte readout of the conversion result. All serial inputs are resynchronised to a fast system clock, and the serial clock is oversampled.

Top module: `sri_top`

## Requirements
- R1: After reset, every writable register holds 0, gain_mux_o is 0, conv_start_o is low, and both output enables are low.
- R2: An instruction with bit 7 = 1 copies bits 6..0 into the gain/mux register (address 4, where bit 7 reads 0), drives gain_mux_o with them and raises conv_start_o for exactly one cycle. No data byte follows and the data line is not driven.
- R3: An instruction with bit 7 = 0 is a register access. Bit 6 = 1 means read, bit 5 = 1 means two bytes, and bits 4..0 give the address. A written byte reads back through the writable-bit mask of its register.
- R4: In a two-byte access, the second byte goes to, or comes from, the address after the one in the instruction.
- R5: With edge_sel = 1, input bits are sampled on rising serial clock edges and output bits change on falling edges. With edge_sel = 0, the roles of the two edges swap.
- R6: During a read, the output is not driven before the inactive edge that follows the 8th active edge. At that inactive edge, the first data bit is driven, so it is valid at the next active edge.
- R7: Bit 0 of register 24 selects LSB-first order (1) or MSB-first order (0). The setting applies to instruction and data bytes, starting with the frame after the write.
- R8: Bit 1 of register 24 selects 2-wire mode. In this mode, din_oe_o and din_o carry the same read data as dout_oe_o and dout_o.
- R9: Bit 2 of register 24 selects early release: the output enable drops at the final active edge of a read. When the bit is clear, the output stays driven until the next inactive edge or until chip select rises.
- R10: Address 1 returns result_i[15:8] and address 2 returns result_i[7:0]. Writes to these two addresses are ignored. Unimplemented addresses read 0. The writable masks are 0x03 for address 3, 0x7F for address 4 and 0x07 for address 24.
- R11: When bits 1..0 of register 3 equal 01, a conversion command is followed in the same frame by a 2-byte read starting at address 1, with no read instruction.
- R12: Raising chip select ends the frame. A partly shifted byte is discarded, and the next frame starts with a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| edge_sel | input | 1 | Strap: 1 = rising edge active, 0 = falling edge active |
| din_i | input | 1 | Serial data from the host |
| result_i | input | 16 | Latest conversion result, read at addresses 1 and 2 |
| din_o | output | 1 | Read data on the data-in line in 2-wire mode |
| din_oe_o | output | 1 | Drive enable for din_o |
| dout_o | output | 1 | Serial read data |
| dout_oe_o | output | 1 | Drive enable for dout_o |
| conv_start_o | output | 1 | One-cycle conversion-start strobe |
| gain_mux_o | output | 7 | Current gain/mux setting |

## Verification
Most faults in the frame state show up in the first read that follows them. A wrong bit counter or a wrong phase puts the output enable on the wrong half of the serial clock, within one serial clock period of the 8th active edge. A wrong address increment shows in the second byte of a 2-byte read. A wrong order flag shows as a mirrored byte in the next frame. A corrupted configuration register shows at the ports only when the next frame uses it, for example as output that is never driven, or as a missing automatic readout after a conversion command.

// File: rtl/sri_pkg.sv
package sri_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int RES_W  = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [ADDR_W-1:0] A_RES_HI = 5'd1;
    localparam logic [ADDR_W-1:0] A_RES_LO = 5'd2;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd3;
    localparam logic [ADDR_W-1:0] A_GMUX   = 5'd4;
    localparam logic [ADDR_W-1:0] A_SER    = 5'd24;

    localparam logic [BYTE_W-1:0] M_CTRL = 8'h03;
    localparam logic [BYTE_W-1:0] M_GMUX = 8'h7F;
    localparam logic [BYTE_W-1:0] M_SER  = 8'h07;

    localparam logic [1:0] RB_AUTO = 2'b01;

    typedef enum logic [1:0] {
        PH_INSTR,
        PH_WRITE,
        PH_READ,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [BYTE_W-1:0] gmux;
        logic [BYTE_W-1:0] ser;
    } cfg_t;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic              two;
        logic              second;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] shin;
        logic [BYTE_W-1:0] obuf;
        logic              obit;
        logic              drive;
        logic              rel_pend;
        logic              conv;
    } fsm_t;

    function automatic logic [BYTE_W-1:0] shift_in(logic [BYTE_W-1:0] cur, logic b, logic lsb);
        return lsb ? {b, cur[BYTE_W-1:1]} : {cur[BYTE_W-2:0], b};
    endfunction

    function automatic logic head_bit(logic [BYTE_W-1:0] w, logic lsb);
        return lsb ? w[0] : w[BYTE_W-1];
    endfunction

    function automatic logic [BYTE_W-1:0] drop_head(logic [BYTE_W-1:0] w, logic lsb);
        return lsb ? {1'b0, w[BYTE_W-1:1]} : {w[BYTE_W-2:0], 1'b0};
    endfunction
endpackage

// File: rtl/sri_sync.sv
module sri_sync #(
    parameter int             WIDTH   = 1,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int CHAIN_W = STAGES * WIDTH;

    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/sri_edge.sv
module sri_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_active,
    output logic act,
    output logic inact
);
    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        rise  = lvl & ~prev_q;
        fall  = ~lvl & prev_q;
        act   = rise_active ? rise : fall;
        inact = rise_active ? fall : rise;
    end
endmodule

// File: rtl/sri_regfile.sv
module sri_regfile
    import sri_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              dir_en,
    input  logic [BYTE_W-2:0] dir_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [RES_W-1:0]  result_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic              lsb_first,
    output logic              two_wire,
    output logic              early_rel,
    output logic              auto_rb,
    output logic [BYTE_W-2:0] gain_mux
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:  cfg_d.ctrl = wr_data & M_CTRL;
                A_GMUX:  cfg_d.gmux = wr_data & M_GMUX;
                A_SER:   cfg_d.ser  = wr_data & M_SER;
                default: ;
            endcase
        end
        if (dir_en) begin
            cfg_d.gmux = {1'b0, dir_data};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (rd_addr)
            A_RES_HI: rd_data = result_i[RES_W-1:BYTE_W];
            A_RES_LO: rd_data = result_i[BYTE_W-1:0];
            A_CTRL:   rd_data = cfg_q.ctrl;
            A_GMUX:   rd_data = cfg_q.gmux;
            A_SER:    rd_data = cfg_q.ser;
            default:  rd_data = '0;
        endcase
    end

    assign lsb_first = cfg_q.ser[0];
    assign two_wire  = cfg_q.ser[1];
    assign early_rel = cfg_q.ser[2];
    assign auto_rb   = (cfg_q.ctrl[1:0] == RB_AUTO);
    assign gain_mux  = cfg_q.gmux[BYTE_W-2:0];
endmodule

// File: rtl/sri_top.sv
module sri_top
    import sri_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             edge_sel,
    input  logic             din_i,
    input  logic [RES_W-1:0] result_i,
    output logic             din_o,
    output logic             din_oe_o,
    output logic             dout_o,
    output logic             dout_oe_o,
    output logic             conv_start_o,
    output logic [6:0]       gain_mux_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic [2:0] raw_w, sync_w;
    logic cs_s, sclk_s, din_s;
    logic act_w, inact_w;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic              dir_en;
    logic [BYTE_W-1:0] rd_data;
    logic              lsb_first, two_wire, early_rel, auto_rb;
    logic [BYTE_W-1:0] nb;

    fsm_t st_d, st_q;

    assign raw_w = {cs_n, sclk, din_i};

    sri_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(raw_w), .q(sync_w)
    );

    assign {cs_s, sclk_s, din_s} = sync_w;

    sri_edge edge_i (
        .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .rise_active(edge_sel),
        .act(act_w), .inact(inact_w)
    );

    sri_regfile regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dir_en(dir_en), .dir_data(nb[BYTE_W-2:0]),
        .rd_addr(st_q.addr), .result_i(result_i), .rd_data(rd_data),
        .lsb_first(lsb_first), .two_wire(two_wire), .early_rel(early_rel),
        .auto_rb(auto_rb), .gain_mux(gain_mux_o)
    );

    always_comb begin
        st_d    = st_q;
        st_d.conv = 1'b0;
        nb      = shift_in(st_q.shin, din_s, lsb_first);
        wr_en   = 1'b0;
        wr_addr = st_q.addr;
        wr_data = nb;
        dir_en  = 1'b0;

        if (cs_s) begin
            st_d.ph       = PH_INSTR;
            st_d.cnt      = '0;
            st_d.second   = 1'b0;
            st_d.two      = 1'b0;
            st_d.drive    = 1'b0;
            st_d.rel_pend = 1'b0;
        end else if (act_w) begin
            st_d.shin = nb;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_BIT) begin
                case (st_q.ph)
                    PH_INSTR: begin
                        st_d.second = 1'b0;
                        if (nb[BYTE_W-1]) begin
                            dir_en    = 1'b1;
                            st_d.conv = 1'b1;
                            if (auto_rb) begin
                                st_d.ph   = PH_READ;
                                st_d.addr = A_RES_HI;
                                st_d.two  = 1'b1;
                            end else begin
                                st_d.ph = PH_DONE;
                            end
                        end else begin
                            st_d.addr = nb[ADDR_W-1:0];
                            st_d.two  = nb[5];
                            st_d.ph   = nb[6] ? PH_READ : PH_WRITE;
                        end
                    end
                    PH_WRITE: begin
                        wr_en = 1'b1;
                        if (st_q.two && !st_q.second) begin
                            st_d.second = 1'b1;
                            st_d.addr   = st_q.addr + 1'b1;
                        end else begin
                            st_d.ph = PH_DONE;
                        end
                    end
                    PH_READ: begin
                        if (st_q.two && !st_q.second) begin
                            st_d.second = 1'b1;
                            st_d.addr   = st_q.addr + 1'b1;
                        end else begin
                            st_d.ph = PH_DONE;
                            if (early_rel) st_d.drive    = 1'b0;
                            else           st_d.rel_pend = 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end else if (inact_w) begin
            if (st_q.ph == PH_READ) begin
                st_d.drive = 1'b1;
                if (st_q.cnt == '0) begin
                    st_d.obit = head_bit(rd_data, lsb_first);
                    st_d.obuf = drop_head(rd_data, lsb_first);
                end else begin
                    st_d.obit = head_bit(st_q.obuf, lsb_first);
                    st_d.obuf = drop_head(st_q.obuf, lsb_first);
                end
            end else if (st_q.rel_pend) begin
                st_d.drive    = 1'b0;
                st_d.rel_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= PH_INSTR;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o       = st_q.obit;
    assign dout_oe_o    = st_q.drive;
    assign din_o        = st_q.obit;
    assign din_oe_o     = st_q.drive & two_wire;
    assign conv_start_o = st_q.conv;
endmodule

// File: rtl/sri_checker.sv
module sri_checker #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic dout_o,
    input logic dout_oe_o,
    input logic din_oe_o,
    input logic conv_start_o,
    input logic inact
);
    localparam int CW    = $clog2(SYNC_STAGES + 4) + 1;
    localparam int LIMIT = SYNC_STAGES + 1;
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [CW-1:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            hi_cnt_q <= '0;
        else if (!cs_n)        hi_cnt_q <= '0;
        else if (hi_cnt_q != CMAX) hi_cnt_q <= hi_cnt_q + 1'b1;
    end

    assert_din_oe_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        din_oe_o |-> dout_oe_o);

    assert_conv_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |=> !conv_start_o);

    assert_cs_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hi_cnt_q) > LIMIT) |-> !dout_oe_o);

    assert_dout_moves_on_inactive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe_o && $past(dout_oe_o) && (dout_o != $past(dout_o))) |-> $past(inact));

    assert_oe_rises_on_inactive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe_o) |-> $past(inact));
endmodule

bind sri_top sri_checker #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
    .din_oe_o(din_oe_o), .conv_start_o(conv_start_o), .inact(inact_w)
);

// File: tb/sri_top_tb_top.sv
`timescale 1ns/100ps
module sri_top_tb_top;
    localparam int HALF = 8;
    localparam int WD   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic edge_sel = 1'b1;
    logic din_i = 1'b0;
    logic [15:0] result_i = 16'h0000;
    logic din_o, din_oe_o, dout_o, dout_oe_o, conv_start_o;
    logic [6:0] gain_mux_o;

    int n_tests = 0;
    int n_fail = 0;
    int conv_cnt = 0;
    bit done = 1'b0;
    bit lsb_m = 1'b0, two_m = 1'b0, early_m = 1'b0;
    logic [7:0] mdl [32];

    always #2.5 clk = ~clk;

    sri_top dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .edge_sel(edge_sel),
        .din_i(din_i), .result_i(result_i), .din_o(din_o), .din_oe_o(din_oe_o),
        .dout_o(dout_o), .dout_oe_o(dout_oe_o), .conv_start_o(conv_start_o),
        .gain_mux_o(gain_mux_o)
    );

    always @(posedge clk) if (rst_n && conv_start_o) conv_cnt++;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_rd(input logic [4:0] a);
        if (a == 5'd1) return result_i[15:8];
        if (a == 5'd2) return result_i[7:0];
        return mdl[a];
    endfunction

    task automatic model_wr(input logic [4:0] a, input logic [7:0] d);
        case (a)
            5'd3:  mdl[3]  = d & 8'h03;
            5'd4:  mdl[4]  = d & 8'h7F;
            5'd24: begin
                mdl[24] = d & 8'h07;
                lsb_m = d[0]; two_m = d[1]; early_m = d[2];
            end
            default: ;
        endcase
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic [7:0] rxd,
                         output logic oe_mid, output logic oe_aft, output logic doe);
        rx = '0; rxd = '0; oe_mid = 1'b0; doe = 1'b0;
        for (int i = 0; i < 8; i++) begin
            int k;
            k = lsb_m ? i : 7 - i;
            din_i = tx[k];
            tick(HALF);
            rx[k] = dout_o;
            rxd[k] = din_o;
            if (i == 7) doe = din_oe_o;
            sclk = edge_sel;
            tick(6);
            if (i == 7) oe_mid = dout_oe_o;
            tick(HALF - 6);
            sclk = ~edge_sel;
        end
        tick(6);
        oe_aft = dout_oe_o;
    endtask

    task automatic begin_f;
        sclk = ~edge_sel;
        tick(4);
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic end_f;
        tick(HALF);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic write8(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] r, rd; logic m, f, o;
        begin_f;
        xbyte({3'b000, a}, r, rd, m, f, o);
        xbyte(d, r, rd, m, f, o);
        end_f;
        model_wr(a, d);
    endtask

    task automatic write16(input logic [4:0] a, input logic [7:0] d0, input logic [7:0] d1);
        logic [7:0] r, rd; logic m, f, o;
        begin_f;
        xbyte({3'b001, a}, r, rd, m, f, o);
        xbyte(d0, r, rd, m, f, o);
        xbyte(d1, r, rd, m, f, o);
        end_f;
        model_wr(a, d0);
        model_wr(a + 5'd1, d1);
    endtask

    task automatic read8(input string tag, input logic [4:0] a);
        logic [7:0] r, rd; logic m, f, o;
        logic [7:0] e;
        e = exp_rd(a);
        begin_f;
        xbyte({3'b010, a}, r, rd, m, f, o);
        chk("R6 idle before inactive edge", m, 1'b0);
        chk("R6 driven after inactive edge", f, 1'b1);
        xbyte(8'h00, r, rd, m, f, o);
        chk(tag, r, e);
        chk("R9 hold at last active edge", m, !early_m);
        chk("R9 released after last inactive edge", f, 1'b0);
        if (two_m) chk("R8 din carries data", rd, e);
        chk("R8 din enable", o, two_m);
        end_f;
    endtask

    task automatic read16(input string tag, input logic [4:0] a);
        logic [7:0] r0, r1, rd; logic m, f, o;
        logic [7:0] e0, e1;
        e0 = exp_rd(a); e1 = exp_rd(a + 5'd1);
        begin_f;
        xbyte({3'b011, a}, r0, rd, m, f, o);
        xbyte(8'h00, r0, rd, m, f, o);
        chk({tag, " first"}, r0, e0);
        chk("R4 still driving between bytes", f, 1'b1);
        xbyte(8'h00, r1, rd, m, f, o);
        chk({tag, " second"}, r1, e1);
        end_f;
    endtask

    task automatic direct(input logic [6:0] g);
        logic [7:0] r0, r1, rd; logic m, f, o;
        int c0;
        bit au;
        au = (mdl[3][1:0] == 2'b01);
        c0 = conv_cnt;
        begin_f;
        xbyte({1'b1, g}, r0, rd, m, f, o);
        if (au) begin
            chk("R11 auto readout drives", f, 1'b1);
            xbyte(8'h00, r0, rd, m, f, o);
            xbyte(8'h00, r1, rd, m, f, o);
            chk("R11 auto readout high byte", r0, result_i[15:8]);
            chk("R11 auto readout low byte", r1, result_i[7:0]);
        end else begin
            chk("R2 no drive after command", f, 1'b0);
        end
        end_f;
        chk("R2 one conversion strobe", conv_cnt, c0 + 1);
        chk("R2 gain_mux_o", gain_mux_o, g);
        mdl[4] = {1'b0, g};
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        chk("R1 dout_oe_o", dout_oe_o, 1'b0);
        chk("R1 din_oe_o", din_oe_o, 1'b0);
        chk("R1 conv_start_o", conv_start_o, 1'b0);
        chk("R1 gain_mux_o", gain_mux_o, 7'h00);
        read8("R1 reg3 reset", 5'd3);
        read8("R1 reg4 reset", 5'd4);
        read8("R1 reg24 reset", 5'd24);

        write8(5'd4, 8'h35);
        read8("R3 write/read reg4", 5'd4);
        chk("R3 gain_mux_o after write", gain_mux_o, 7'h35);
        write8(5'd3, 8'h02);
        read8("R3 write/read reg3", 5'd3);

        result_i = 16'hA5C3;
        read8("R10 result high", 5'd1);
        read8("R10 result low", 5'd2);
        write8(5'd1, 8'hFF);
        read8("R10 read-only ignores write", 5'd1);
        write8(5'd4, 8'hFF);
        read8("R10 reg4 mask", 5'd4);
        write8(5'd9, 8'h12);
        read8("R10 unimplemented reads 0", 5'd9);

        write16(5'd3, 8'h02, 8'h5A);
        read8("R4 first byte address", 5'd3);
        read8("R4 second byte next address", 5'd4);
        read16("R4 two-byte read", 5'd1);

        direct(7'h2B);
        read8("R2 gain/mux register", 5'd4);

        write8(5'd3, 8'h01);
        result_i = 16'h3C96;
        direct(7'h11);
        write8(5'd3, 8'h00);
        direct(7'h22);

        write8(5'd24, 8'h01);
        write8(5'd4, 8'h4E);
        read8("R7 lsb-first round trip", 5'd4);
        read16("R7 lsb-first two-byte", 5'd1);
        direct(7'h0D);

        write8(5'd24, 8'h02);
        read8("R8 two-wire read", 5'd4);
        read16("R8 two-wire two-byte", 5'd1);

        write8(5'd24, 8'h04);
        read8("R9 early release read", 5'd2);
        write8(5'd24, 8'h07);
        read8("R9 early lsb two-wire", 5'd1);
        write8(5'd24, 8'h00);

        edge_sel = 1'b0;
        tick(20);
        write8(5'd4, 8'h63);
        read8("R5 falling-active read", 5'd4);
        read16("R5 falling-active two-byte", 5'd1);
        edge_sel = 1'b1;
        tick(20);

        begin
            logic [7:0] r, rd; logic m, f, o;
            begin_f;
            xbyte({3'b000, 5'd4}, r, rd, m, f, o);
            for (int i = 0; i < 5; i++) begin
                din_i = 1'b1;
                tick(HALF);
                sclk = edge_sel;
                tick(HALF);
                sclk = ~edge_sel;
            end
            tick(HALF);
            cs_n = 1'b1;
            tick(10);
        end
        read8("R12 aborted byte not written", 5'd4);
        chk("R12 released with cs high", dout_oe_o, 1'b0);

        for (int it = 0; it < 60; it++) begin
            logic [4:0] a;
            logic [7:0] d;
            a = 5'($urandom_range(0, 23));
            d = 8'($urandom);
            result_i = 16'($urandom);
            if (($urandom % 5) == 0) begin
                direct(7'($urandom));
            end else begin
                write8(a, d);
                read8("R3 random round trip", a);
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule